// File: doc/BRIEF.md
# Trigger-Centred Tick History Capture

This block watches a small group of channel lines and records their state on every beam tick strobe. It always keeps the previous tick's sample, so the tick before a trigger is still on hand when the trigger arrives. A trigger pulse that arrives together with a tick strobe marks that tick as the triggered tick. The block then keeps sampling for two more ticks. It packs the four samples into one states word, with the oldest sample in the low nibble.

Once the window is complete, a ready flag rises. A reader then pulls two words through a word-serial port, one read strobe per word. The first word is the states word. The second is a status word built from FIFO error flags and the read and write counters supplied at the block's inputs. In compatibility mode the second word is a plain copy of the states word. A trigger that arrives while a window is filling or waiting to be read is dropped, and a sticky overlap flag records it.

Top module: `tick_window_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, ready_o, overlap_o, dvalid_o and dout_o are all 0, and the history sample is cleared to 0.
- R2: The states word holds the channels at the tick before the trigger in bits 3:0, at the triggered tick in bits 7:4, at the next tick in bits 11:8 and at the tick after that in bits 15:12. Channels are sampled only in cycles where tick_i is high.
- R3: When compat_i is 0, the second word read is {rd_rst_i, rd_cnt_i[4:0], wr_rst_i, wr_cnt_i[4:0], fifo_err_i[3:0]}. Bit 0 is FIFO full, bit 1 FIFO empty, bit 2 missing gap and bit 3 unexpected gap. The inputs are sampled in the cycle of the second read strobe.
- R4: When compat_i is 1 in the cycle of the second read strobe, the second word equals the states word.
- R5: ready_o rises on the clock edge that takes the second tick strobe after the triggered tick. Cycles without a tick strobe do not advance the window.
- R6: A trigger with a tick strobe is dropped while a window is filling or ready, and the held word is unchanged. Such a trigger sets overlap_o on that edge. overlap_o is cleared by an accepted read strobe, and a set in the same cycle wins over the clear.
- R7: An accepted read strobe (rd_i high while ready_o is high) puts a word on dout_o with dvalid_o high in the following cycle. The first read returns the states word and the second returns the second word. ready_o falls on the edge of the second read.
- R8: trig_i without tick_i in the same cycle starts no window. rd_i while ready_o is low produces no dvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Beam tick strobe, one cycle per tick |
| chan_i | input | NCH (4) | Channel states sampled on tick strobes |
| trig_i | input | 1 | Marks the tick strobed in the same cycle as the triggered tick |
| rd_i | input | 1 | Read strobe, one word per strobe |
| compat_i | input | 1 | 1: second word repeats the states word |
| fifo_err_i | input | 4 | FIFO error flags for the status word |
| wr_cnt_i | input | 5 | FIFO write counter |
| wr_rst_i | input | 1 | Write-counter reset indication |
| rd_cnt_i | input | 5 | FIFO read counter |
| rd_rst_i | input | 1 | Read-counter reset indication |
| ready_o | output | 1 | Window complete, words waiting |
| overlap_o | output | 1 | Sticky: a trigger was dropped |
| dout_o | output | NCH*(PRE+1+POST) (16) | Readout word |
| dvalid_o | output | 1 | dout_o carries a word this cycle |

## Verification
ready_o is due on the edge of the second post-trigger tick strobe, however many idle cycles lie between the ticks. dout_o and dvalid_o are due one cycle after the accepted read strobe. overlap_o changes on the same edge as the trigger or read that sets or clears it. The bench's reference model keeps every tick sample in a queue and records the queue index of the triggered tick. On each edge it works out which outputs must change, and the bench compares all outputs at the falling edge that follows. Long random runs with irregular tick spacing, stray triggers and early reads then hit each of these due cycles many times.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int CNT_W  = 5;
  localparam int ERR_W  = 4;
  localparam int STAT_W = 2 + 2 * CNT_W + ERR_W;

  typedef enum logic [1:0] {WIN_IDLE, WIN_FILL, WIN_HELD} win_state_e;

  // field order is fixed by the downstream decoder (MSB first)
  typedef struct packed {
    logic             rd_rst;
    logic [CNT_W-1:0] rd_cnt;
    logic             wr_rst;
    logic [CNT_W-1:0] wr_cnt;
    logic [ERR_W-1:0] err;
  } fifo_stat_t;
endpackage

// File: rtl/twc_history.sv
module twc_history #(
  parameter int NCH   = 4,
  parameter int DEPTH = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic [NCH-1:0]         chan,
  output logic [DEPTH*NCH-1:0]   hist
);
  logic [NCH-1:0] hq [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        hq[i] <= '0;
      else if (tick)
        hq[i] <= (i == 0) ? chan : hq[(i == 0) ? 0 : i - 1];
    end
    assign hist[i*NCH +: NCH] = hq[i];
  end
endmodule

// File: rtl/twc_window.sv
module twc_window
  import twc_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int PRE  = 1,
  parameter int POST = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [NCH-1:0]               chan,
  input  logic                         trig,
  input  logic [PRE*NCH-1:0]           hist,
  input  logic                         rd_acc,
  input  logic                         rd_done,
  output logic [NCH*(PRE+1+POST)-1:0]  word,
  output logic                         ready,
  output logic                         overlap
);
  localparam int WIN    = PRE + 1 + POST;
  localparam int CW     = $clog2(POST + 1);
  localparam int SLOT_W = $clog2(WIN);

  win_state_e           state_q;
  logic [CW-1:0]        left_q;
  logic [NCH*WIN-1:0]   word_q;
  logic                 ovl_q;
  logic                 trig_ok;
  logic [SLOT_W-1:0]    fill_slot;

  assign trig_ok   = trig & tick;
  assign fill_slot = SLOT_W'(WIN - int'(left_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WIN_IDLE;
      left_q  <= '0;
      word_q  <= '0;
    end else begin
      case (state_q)
        WIN_IDLE: if (trig_ok) begin
          for (int i = 0; i < PRE; i++)
            word_q[(PRE-1-i)*NCH +: NCH] <= hist[i*NCH +: NCH];
          word_q[PRE*NCH +: NCH] <= chan;
          left_q  <= CW'(POST);
          state_q <= WIN_FILL;
        end
        WIN_FILL: if (tick) begin
          word_q[int'(fill_slot)*NCH +: NCH] <= chan;
          left_q <= left_q - 1'b1;
          if (left_q == CW'(1)) state_q <= WIN_HELD;
        end
        default: if (rd_done) state_q <= WIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ovl_q <= 1'b0;
    else if (trig_ok && state_q != WIN_IDLE)
      ovl_q <= 1'b1;
    else if (rd_acc)
      ovl_q <= 1'b0;
  end

  assign word    = word_q;
  assign ready   = (state_q == WIN_HELD);
  assign overlap = ovl_q;

  assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(tick));
  assert_overlap_set_R6: assert property (@(posedge clk) disable iff (rst)
    (trig && tick && !ready && state_q != WIN_IDLE) || (trig && tick && ready) |=> overlap);
  assert_word_held_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> $stable(word_q));
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(rd_done));
endmodule

// File: rtl/twc_readout.sv
module twc_readout
  import twc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd,
  input  logic           ready,
  input  logic [DW-1:0]  word,
  input  fifo_stat_t     stat,
  input  logic           compat,
  output logic [DW-1:0]  dout,
  output logic           dvalid,
  output logic           rd_acc,
  output logic           rd_done
);
  logic          second_q;
  logic [DW-1:0] dout_q;
  logic          dv_q;

  assign rd_acc  = rd & ready;
  assign rd_done = rd_acc & second_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q <= 1'b0;
      dout_q   <= '0;
      dv_q     <= 1'b0;
    end else begin
      dv_q <= rd_acc;
      if (rd_acc) begin
        second_q <= ~second_q;
        if (!second_q || compat)
          dout_q <= word;
        else
          dout_q <= DW'(stat);
      end
    end
  end

  assign dout   = dout_q;
  assign dvalid = dv_q;

  assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> $past(rd && ready));
  assert_compat_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && second_q && compat) |=> (dout == $past(word)));
  assert_idle_read_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !ready) |=> !dvalid);
endmodule

// File: rtl/tick_window_capture.sv
module tick_window_capture
  import twc_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int PRE  = 1,
  parameter int POST = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_i,
  input  logic [NCH-1:0]              chan_i,
  input  logic                        trig_i,
  input  logic                        rd_i,
  input  logic                        compat_i,
  input  logic [ERR_W-1:0]            fifo_err_i,
  input  logic [CNT_W-1:0]            wr_cnt_i,
  input  logic                        wr_rst_i,
  input  logic [CNT_W-1:0]            rd_cnt_i,
  input  logic                        rd_rst_i,
  output logic                        ready_o,
  output logic                        overlap_o,
  output logic [NCH*(PRE+1+POST)-1:0] dout_o,
  output logic                        dvalid_o
);
  localparam int DW = NCH * (PRE + 1 + POST);

  logic [PRE*NCH-1:0] hist;
  logic [DW-1:0]      word;
  logic               ready, rd_acc, rd_done;
  fifo_stat_t         stat;

  assign stat = '{rd_rst: rd_rst_i, rd_cnt: rd_cnt_i, wr_rst: wr_rst_i,
                  wr_cnt: wr_cnt_i, err: fifo_err_i};

  twc_history #(.NCH(NCH), .DEPTH(PRE)) u_hist (
    .clk(clk), .rst(rst), .tick(tick_i), .chan(chan_i), .hist(hist));

  twc_window #(.NCH(NCH), .PRE(PRE), .POST(POST)) u_win (
    .clk(clk), .rst(rst), .tick(tick_i), .chan(chan_i), .trig(trig_i),
    .hist(hist), .rd_acc(rd_acc), .rd_done(rd_done),
    .word(word), .ready(ready), .overlap(overlap_o));

  twc_readout #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd(rd_i), .ready(ready), .word(word),
    .stat(stat), .compat(compat_i), .dout(dout_o), .dvalid(dvalid_o),
    .rd_acc(rd_acc), .rd_done(rd_done));

  assign ready_o = ready;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!ready_o && !dvalid_o && !overlap_o));
endmodule

// File: tb/tick_window_capture_tb_top.sv
module tick_window_capture_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, trig = 0, rd = 0, compat = 0, wrst = 0, rrst = 0;
  logic [3:0] ch = '0, err = '0;
  logic [4:0] wc = '0, rc = '0;
  logic ready_o, overlap_o, dvalid_o;
  logic [15:0] dout_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [3:0] samp[$];
  int tt;
  bit mbusy, mready, mphase, movl, mdv;
  logic [15:0] mdout;
  string mtag;

  always #10 clk = ~clk;

  tick_window_capture dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .chan_i(ch), .trig_i(trig),
    .rd_i(rd), .compat_i(compat), .fifo_err_i(err), .wr_cnt_i(wc),
    .wr_rst_i(wrst), .rd_cnt_i(rc), .rd_rst_i(rrst),
    .ready_o(ready_o), .overlap_o(overlap_o), .dout_o(dout_o),
    .dvalid_o(dvalid_o));

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    samp.delete();
    samp.push_back(4'h0);
    tt = 0; mbusy = 0; mready = 0; mphase = 0; movl = 0; mdv = 0;
    mdout = '0; mtag = "R1";
  endtask

  // Behavioural reference: every tick sample kept, window located by index
  task automatic model_step();
    int n;
    bit acc, ovl_set, nbusy, nready;
    logic [15:0] w;
    n = samp.size();
    acc = rd && mready;
    nbusy = mbusy; nready = mready; ovl_set = 0;
    if (trig && tick) begin
      if (!mbusy && !mready) begin nbusy = 1; tt = n; end
      else ovl_set = 1;
    end
    if (mbusy && tick && n == tt + 2) begin nbusy = 0; nready = 1; end
    if (tick) samp.push_back(ch);
    mdv = acc;
    if (acc) begin
      w = {samp[tt+2], samp[tt+1], samp[tt], samp[tt-1]};
      if (!mphase) begin mdout = w; mtag = "R2"; end
      else if (compat) begin mdout = w; mtag = "R4"; end
      else begin mdout = {rrst, rc, wrst, wc, err}; mtag = "R3"; end
      if (mphase) nready = 0;
      mphase = !mphase;
      movl = 0;
    end
    if (ovl_set) movl = 1;
    mbusy = nbusy; mready = nready;
  endtask

  task automatic compare();
    check(ready_o == mready, "R5 ready", 16'(ready_o), 16'(mready));
    check(overlap_o == movl, "R6 overlap", 16'(overlap_o), 16'(movl));
    check(dvalid_o == mdv, "R7 dvalid", 16'(dvalid_o), 16'(mdv));
    if (mdv) check(dout_o == mdout, mtag, dout_o, mdout);
  endtask

  // called at a falling edge: drive, take one rising edge, compare at next fall
  task automatic cyc(input bit tk, input logic [3:0] c, input bit tg, input bit r);
    tick = tk; ch = c; trig = tg; rd = r;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 4'hF, 0, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(ready_o == 0 && dvalid_o == 0 && overlap_o == 0 && dout_o == 0,
          "R1 reset", {ready_o, overlap_o, dvalid_o, dout_o[12:0]}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check(ready_o == 0 && dvalid_o == 0 && overlap_o == 0 && dout_o == 0,
          "R1 after reset", {ready_o, overlap_o, dvalid_o, dout_o[12:0]}, 16'h0);

    // R2/R3: spaced ticks, trigger, two reads with status
    cyc(1, 4'h3, 0, 0); idle(2);
    cyc(1, 4'hA, 1, 0); idle(3);
    cyc(1, 4'h5, 0, 0); idle(1);
    check(ready_o == 0, "R5 not yet ready", 16'(ready_o), 16'h0);
    cyc(1, 4'hC, 0, 0);
    check(ready_o == 1, "R5 ready after second tick", 16'(ready_o), 16'h1);
    err = 4'h9; wc = 5'h15; wrst = 1; rc = 5'h0A; rrst = 0;
    cyc(0, 4'h0, 0, 1);
    check(dout_o == 16'hC5A3, "R2 states word", dout_o, 16'hC5A3);
    idle(2);
    cyc(0, 4'h0, 0, 1);
    check(dout_o == {1'b0, 5'h0A, 1'b1, 5'h15, 4'h9}, "R3 status word",
          dout_o, {1'b0, 5'h0A, 1'b1, 5'h15, 4'h9});
    check(ready_o == 0, "R7 ready falls", 16'(ready_o), 16'h0);

    // R4 compat, R6 overlap during fill and hold
    compat = 1;
    cyc(1, 4'h1, 1, 0);
    cyc(1, 4'h2, 1, 0);
    check(overlap_o == 1, "R6 overlap in fill", 16'(overlap_o), 16'h1);
    cyc(1, 4'h4, 0, 0);
    cyc(1, 4'h8, 1, 0);
    cyc(0, 4'h0, 0, 1);
    check(dout_o == 16'h421C && overlap_o == 0, "R6 word kept, cleared",
          dout_o, 16'h421C);
    cyc(1, 4'h7, 1, 1);
    check(dout_o == 16'h421C && overlap_o == 1, "R4 copy, R6 set wins",
          dout_o, 16'h421C);

    // R8: trigger without tick, read while not ready
    cyc(0, 4'h6, 1, 0); cyc(1, 4'h6, 0, 0); cyc(1, 4'h6, 0, 1);
    check(ready_o == 0 && dvalid_o == 0, "R8 ignored", {ready_o, dvalid_o}, 16'h0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      compat = 1'($urandom); err = 4'($urandom); wc = 5'($urandom);
      rc = 5'($urandom); wrst = 1'($urandom); rrst = 1'($urandom);
      cyc(($urandom % 2) == 0, 4'($urandom), ($urandom % 6) == 0,
          ($urandom % 4) == 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule